// File: doc/BRIEF.md
# Command-Window Bus Bridge

This block lets a host that only issues 64-bit register accesses reach a 32-bit internal bus without mapping that bus directly. The host sees four 64-bit registers. A single write to the command register starts one internal-bus transfer, either a read or a write, at the 32-bit address carried in that command. There is no separate go bit. Write data comes from a separately loaded data register. The outcome of the transfer appears in a status register, which clears itself when the host reads it.

The register is chosen by bits [4:3] of the host address, so the four registers repeat every 32 bytes. Field positions follow a numbering where bit 0 is the most significant bit of the 64-bit word. In the requirements every position is also given as a conventional LSB-0 index. The internal side is a plain request/acknowledge master. It holds its request until the target answers with either an acknowledge or an error.

Top module: `cmdwin_bridge`

## Requirements
- R1: The register index is hostAddr[4:3]: 0 is command, 1 is reset, 2 is status and 3 is data. Address bits above bit 4 are ignored, so address 0x38 reaches the data register and address 0x20 reaches the command register.
- R2: A command write while idle raises busReq on the next clock. The transfer takes its fields from the command word: busAddr = wdata[31:0] (MSB-0 bits 32–63), busSize = wdata[59:56] (MSB-0 bits 4–7), and busWr = NOT wdata[48] (MSB-0 bit 15, where 1 means read).
- R3: busReq stays high, and busAddr stays stable, until busAck or busErr is seen. busReq drops on the clock after that response.
- R4: When a read is acknowledged, status becomes the done flag, bit 11 (MSB-0 bit 52), OR the 32-bit busRdata placed in status bits [57:26]. The first byte on the bus, busRdata[31:24], lands in the most significant position of that field.
- R5: When a read ends with busErr, status becomes the done flag OR all-ones in bits [57:26], which is 0x03FF_FFFF_FC00_0800.
- R6: A write transfer drives the stored data register on busWdata, with its most significant byte in busWdata[31:24]. On completion, by acknowledge or by error, status is exactly 0x800.
- R7: A status read returns the current value, and status is zero afterwards. Host writes to status leave it unchanged.
- R8: A data-register write stores wdata[63:32], and a read returns it in [63:32] with zeros below. Command and reset registers always read as zero. A write to the reset register has no effect.
- R9: While a transfer is in progress, status reads as zero, and a command write is ignored: it neither restarts nor changes the running transfer.
- R10: After reset, busReq is low, and both status and data read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access strobe, one cycle per access |
| hostWr | input | 1 | 1 = write, 0 = read |
| hostAddr | input | HOST_AW | Host byte address |
| hostWdata | input | 64 | Host write data |
| hostRdata | output | 64 | Host read data, valid in the cycle of a read |
| busReq | output | 1 | Internal-bus request, held until a response |
| busWr | output | 1 | Internal-bus direction, 1 = write |
| busAddr | output | 32 | Internal-bus address |
| busSize | output | 4 | Transfer size from the command |
| busWdata | output | 32 | Internal-bus write data |
| busRdata | input | 32 | Internal-bus read data, taken in the acknowledge cycle |
| busAck | input | 1 | Target acknowledge |
| busErr | input | 1 | Target error |

## Verification
The assertions check the following on every cycle:
- the request is held until a response arrives, and dropped once it does;
- the latched address stays stable while the request is up;
- status stays zero while a transfer is in flight;
- status clears after it is read;
- the done flag is present after every completion.

Only the bench's scenarios can show the rest:
- the exact packing of read data and of the all-ones error pattern;
- the write data presented to the bus;
- address aliasing of the register index;
- that a command write during a transfer leaves the running transfer untouched.

// File: rtl/cmdwin_pkg.sv
package cmdwin_pkg;
  localparam int WORD_W   = 64;
  localparam int BUS_AW   = 32;
  localparam int BUS_DW   = 32;
  localparam int SIZE_W   = 4;
  // MSB-0 positions converted to LSB-0 indices
  localparam int RD_BIT   = WORD_W - 1 - 15;   // 48
  localparam int SIZE_LSB = WORD_W - 1 - 7;    // 56
  localparam int DONE_BIT = WORD_W - 1 - 52;   // 11
  localparam int RD_SHIFT = WORD_W - 1 - 37;   // 26

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_RST  = 2'd1,
    REG_STAT = 2'd2,
    REG_DATA = 2'd3
  } regIdx_e;

  typedef struct packed {
    logic loadData;
    logic startXfer;
    logic endOk;
    logic endErr;
    logic clrStat;
  } strobe_t;
endpackage

// File: rtl/cmdwin_ctrl.sv
module cmdwin_ctrl
  import cmdwin_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    hostSel,
  input  logic    hostWr,
  input  regIdx_e regIdx,
  input  logic    busAck,
  input  logic    busErr,
  output logic    busy,
  output strobe_t strb
);
  logic wrAccess, rdAccess;

  assign wrAccess = hostSel && hostWr;
  assign rdAccess = hostSel && !hostWr;

  always_comb begin
    strb.loadData  = wrAccess && (regIdx == REG_DATA);
    strb.startXfer = wrAccess && (regIdx == REG_CMD) && !busy;
    strb.endOk     = busy && busAck;
    strb.endErr    = busy && busErr && !busAck;
    strb.clrStat   = rdAccess && (regIdx == REG_STAT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else if (strb.startXfer) begin
      busy <= 1'b1;
    end else if (strb.endOk || strb.endErr) begin
      busy <= 1'b0;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busy && !busAck && !busErr |=> busy) else $error("request dropped early"); // R3
  AST_END_DROPS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busy && (busAck || busErr) |=> !busy) else $error("request held after response"); // R3
endmodule

// File: rtl/cmdwin_dpath.sv
module cmdwin_dpath
  import cmdwin_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strb,
  input  logic                busy,
  input  regIdx_e             regIdx,
  input  logic [WORD_W-1:0]   hostWdata,
  output logic [WORD_W-1:0]   hostRdata,
  output logic                busWr,
  output logic [BUS_AW-1:0]   busAddr,
  output logic [SIZE_W-1:0]   busSize,
  output logic [BUS_DW-1:0]   busWdata,
  input  logic [BUS_DW-1:0]   busRdata
);
  localparam logic [WORD_W-1:0] DONE_MASK = WORD_W'(1) << DONE_BIT;

  logic                xIsRd;
  logic [BUS_AW-1:0]   xAddr;
  logic [SIZE_W-1:0]   xSize;
  logic [BUS_DW-1:0]   dataReg;
  logic [WORD_W-1:0]   statReg;
  logic [BUS_DW-1:0]   rdWord;
  logic [WORD_W-1:0]   statNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xIsRd <= 1'b0;
      xAddr <= '0;
      xSize <= '0;
    end else if (strb.startXfer) begin
      xIsRd <= hostWdata[RD_BIT];
      xAddr <= hostWdata[BUS_AW-1:0];
      xSize <= hostWdata[SIZE_LSB +: SIZE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strb.loadData) begin
      dataReg <= hostWdata[WORD_W-1 -: BUS_DW];
    end
  end

  assign rdWord = strb.endOk ? busRdata : '1;

  always_comb begin
    if (xIsRd) begin
      statNext = DONE_MASK | (WORD_W'(rdWord) << RD_SHIFT);
    end else begin
      statNext = DONE_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statReg <= '0;
    end else if (strb.endOk || strb.endErr) begin
      statReg <= statNext;
    end else if (strb.startXfer || strb.clrStat) begin
      statReg <= '0;
    end
  end

  always_comb begin
    unique case (regIdx)
      REG_STAT: hostRdata = statReg;
      REG_DATA: hostRdata = {dataReg, {(WORD_W-BUS_DW){1'b0}}};
      default:  hostRdata = '0;
    endcase
  end

  assign busWr    = !xIsRd;
  assign busAddr  = xAddr;
  assign busSize  = xSize;
  assign busWdata = dataReg;

  AST_BUSY_STAT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> statReg == '0) else $error("status nonzero in flight"); // R9
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rstN)
    busy && $past(busy) |-> $stable(xAddr) && $stable(xIsRd)) else $error("command changed in flight"); // R3
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStat && !strb.endOk && !strb.endErr |=> statReg == '0) else $error("status not cleared"); // R7
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.endOk || strb.endErr |=> statReg[DONE_BIT]) else $error("done missing"); // R4
endmodule

// File: rtl/cmdwin_bridge.sv
module cmdwin_bridge
  import cmdwin_pkg::*;
#(
  parameter int HOST_AW = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostSel,
  input  logic               hostWr,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [63:0]        hostWdata,
  output logic [63:0]        hostRdata,
  output logic               busReq,
  output logic               busWr,
  output logic [31:0]        busAddr,
  output logic [3:0]         busSize,
  output logic [31:0]        busWdata,
  input  logic [31:0]        busRdata,
  input  logic               busAck,
  input  logic               busErr
);
  regIdx_e regIdx;
  strobe_t strb;
  logic    busy;

  assign regIdx = regIdx_e'(hostAddr[4:3]);
  assign busReq = busy;

  cmdwin_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostSel (hostSel),
    .hostWr  (hostWr),
    .regIdx  (regIdx),
    .busAck  (busAck),
    .busErr  (busErr),
    .busy    (busy),
    .strb    (strb)
  );

  cmdwin_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busy      (busy),
    .regIdx    (regIdx),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .busSize   (busSize),
    .busWdata  (busWdata),
    .busRdata  (busRdata)
  );
endmodule

// File: tb/sim_cmdwin_bridge.sv
module sim_cmdwin_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWr = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [63:0] hostWdata = '0;
  logic [63:0] hostRdata;
  logic        busReq, busWr;
  logic [31:0] busAddr, busWdata;
  logic [3:0]  busSize;
  logic [31:0] busRdata = '0;
  logic        busAck = 1'b0;
  logic        busErr = 1'b0;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];

  // responder settings and captures
  int          respLat = 1;
  bit          respErr = 0;
  logic [31:0] respData = '0;
  int          reqCnt = 0;
  int          capCnt = 0;
  logic        capWr;
  logic [31:0] capAddr, capWdata;
  logic [3:0]  capSize;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmdwin_bridge u0 (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .busReq(busReq), .busWr(busWr), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .busRdata(busRdata), .busAck(busAck), .busErr(busErr)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
    end
  endtask

  // internal-bus target model
  initial begin
    forever begin
      @(negedge clk);
      busAck = 1'b0;
      busErr = 1'b0;
      if (busReq) begin
        reqCnt++;
        if (reqCnt == respLat) begin
          capCnt   = reqCnt;
          capWr    = busWr;
          capAddr  = busAddr;
          capWdata = busWdata;
          capSize  = busSize;
          busRdata = respData;
          if (respErr) busErr = 1'b1;
          else         busAck = 1'b1;
        end
      end else begin
        reqCnt = 0;
      end
    end
  end

  // monitor: compare each host read against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (hostSel && !hostWr) begin
        if (expQ.size() == 0) begin
          check(1'b0, "scoreboard-empty", hostRdata, 64'h0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          check(hostRdata === it.exp, it.tag, hostRdata, it.exp);
        end
      end
    end
  end

  task automatic hostWrite(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostSel = 1'b0; hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [15:0] a, input logic [63:0] exp, input string tag);
    item_t it;
    it.exp = exp;
    it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    hostSel = 1'b1; hostWr = 1'b0; hostAddr = a;
    @(negedge clk);
    hostSel = 1'b0;
  endtask

  task automatic waitIdle();
    while (busReq) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  localparam logic [63:0] DONE = 64'h800;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: reset state
    @(negedge clk);
    check(busReq === 1'b0, "R10 busReq after reset", {63'b0, busReq}, 64'h0);
    hostRead(16'h10, 64'h0, "R10 status after reset");
    hostRead(16'h18, 64'h0, "R10 data after reset");

    // R8: data register, command/reset read zero, reset write inert
    hostWrite(16'h18, 64'hDEADBEEF_12345678);
    hostRead(16'h18, 64'hDEADBEEF_00000000, "R8 data readback");
    hostRead(16'h00, 64'h0, "R8 command reads zero");
    hostRead(16'h08, 64'h0, "R8 reset reads zero");
    hostWrite(16'h08, 64'hFFFFFFFF_FFFFFFFF);
    hostRead(16'h18, 64'hDEADBEEF_00000000, "R8 reset write no effect on data");
    hostRead(16'h10, 64'h0, "R8 reset write no effect on status");
    check(busReq === 1'b0, "R8 reset write starts nothing", {63'b0, busReq}, 64'h0);

    // R2/R4/R9: read transfer with long latency
    respLat = 6; respErr = 0; respData = 32'h12345678;
    hostWrite(16'h00, (64'h1 << 48) | (64'h4 << 56) | 64'hC001_2038);
    check(busReq === 1'b1, "R2 request raised", {63'b0, busReq}, 64'h1);
    hostRead(16'h10, 64'h0, "R9 status zero in flight");
    hostWrite(16'h00, 64'h0000_0000_0000_1111);   // R9: ignored
    waitIdle();
    check(capAddr === 32'hC001_2038, "R2/R9 bus address", {32'b0, capAddr}, 64'hC001_2038);
    check(capWr === 1'b0, "R2 direction read", {63'b0, capWr}, 64'h0);
    check(capSize === 4'h4, "R2 size field", {60'b0, capSize}, 64'h4);
    check(capCnt == 6, "R3 request held until ack", 64'(capCnt), 64'd6);
    hostRead(16'h10, DONE | (64'h12345678 << 26), "R4 read status");
    hostRead(16'h10, 64'h0, "R7 status cleared by read");
    check(busReq === 1'b0, "R9 ignored command started nothing", {63'b0, busReq}, 64'h0);

    // R5: read error
    respLat = 2; respErr = 1; respData = 32'h0;
    hostWrite(16'h00, (64'h1 << 48) | 64'h0000_0040);
    waitIdle();
    hostRead(16'h10, 64'h03FF_FFFF_FC00_0800, "R5 read error status");

    // R6: write transfer, acknowledged
    respLat = 3; respErr = 0;
    hostWrite(16'h18, 64'hA5B6C7D8_00000000);
    hostWrite(16'h00, (64'h2 << 56) | 64'h0000_0012);
    waitIdle();
    check(capWr === 1'b1, "R6 direction write", {63'b0, capWr}, 64'h1);
    check(capWdata === 32'hA5B6C7D8, "R6 write data", {32'b0, capWdata}, 64'hA5B6C7D8);
    check(capSize === 4'h2, "R2 size on write", {60'b0, capSize}, 64'h2);
    hostRead(16'h10, DONE, "R6 write status");

    // R6: write error still reports done only; R7: status write ignored
    respLat = 1; respErr = 1;
    hostWrite(16'h00, 64'h0000_0000_0000_0099);
    waitIdle();
    hostWrite(16'h10, 64'h0);
    hostRead(16'h10, DONE, "R6/R7 write-error status after ignored status write");

    // R1: aliasing of the register index
    hostWrite(16'h38, 64'h0BAD_F00D_0000_0000);
    hostRead(16'h18, 64'h0BAD_F00D_0000_0000, "R1 data via alias 0x38");
    hostRead(16'h30, 64'h0, "R1 status via alias 0x30");
    respLat = 2; respErr = 0; respData = 32'h00FF_0102;
    hostWrite(16'h20, (64'h1 << 48) | 64'h0000_7777);
    waitIdle();
    check(capAddr === 32'h0000_7777, "R1 command via alias 0x20", {32'b0, capAddr}, 64'h7777);
    hostRead(16'h10, DONE | (64'h00FF_0102 << 26), "R1/R4 read status after aliased command");

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "scoreboard drained", 64'(expQ.size()), 64'h0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule